// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects interrupt requests from eight inputs and presents one interrupt line to a processor. Requests are latched in a pending register, filtered by a mask register and ranked by priority. A request is delivered only if it outranks everything the processor is already servicing. The processor answers with two acknowledge pulses. The first pulse picks the winner and moves it from pending to in-service. The second pulse puts an 8-bit vector on the data output: the upper five bits come from a programmed base and the low three bits give the input number.

Software drives the block through a small write port with two addresses. An initialization word at address 0 selects edge or level triggering, automatic end-of-interrupt and automatic rotation, and clears all state. The next write at address 1 sets the vector base, and any later write at address 1 loads the mask. Other address-0 writes are operation commands. They end an interrupt, either the highest-ranked one in service or a named one, and they can also rotate the priority order. When a request vanishes before the first acknowledge pulse, the block returns the input-7 vector as a spurious answer and records nothing.

Top module: `pic8_intc`

## Requirements
- R1: After reset, intReq and vecValid are low, the mask is all zero, the vector base is zero, triggering is edge mode, and priority is fixed with input 0 highest and input 7 lowest.
- R2: A write with wrAddr=0 and wrData[4]=1 is an init word: it clears pending, in-service and mask and restores input 0 as highest priority. Its bit 3 selects level mode, bit 1 selects automatic end-of-interrupt and bit 2 selects automatic rotation. The next wrAddr=1 write loads the vector base from wrData[7:3]. Every later wrAddr=1 write loads the mask, where bit n blocks input n.
- R3: In edge mode, a request is latched on a low-to-high transition of irq[n] and is dropped if irq[n] falls. A level that is still held after acknowledge does not latch again. intReq rises in the cycle after the clock edge that samples the rise.
- R4: In level mode, pending bit n follows irq[n] on every clock edge and needs no edge to set it.
- R5: A masked input never raises intReq and never wins an acknowledge.
- R6: A request raises intReq only when its priority is strictly higher than that of every in-service input.
- R7: The first ackPulse moves the highest-priority deliverable request from pending to in-service. The second ackPulse drives vecOut = {base, input number} and holds vecValid high for exactly the next cycle.
- R8: If no request is deliverable at the first ackPulse, the vector carries input number 7 and no in-service bit is set.
- R9: The command wrData[7:5]=001 (with wrAddr=0, wrData[4:3]=00) clears the highest-priority set in-service bit.
- R10: The command wrData[7:5]=011 clears the in-service bit named by wrData[2:0].
- R11: The commands 101 (highest-priority bit) and 111 (named bit) end the interrupt in the same way and also make the cleared input the lowest priority. The input after it becomes the highest.
- R12: In automatic end-of-interrupt mode, the second ackPulse clears the acknowledged in-service bit. With automatic rotation also selected, that input becomes the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irq | input | 8 | Request inputs, bit n is input n |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register address |
| wrData | input | 8 | Register write data |
| ackPulse | input | 1 | One-cycle acknowledge pulse, two per handshake |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector from the last completed handshake |
| vecValid | output | 1 | High for one cycle after the second acknowledge pulse |

## Verification
Pending state is registered, so an input change or a mask or command write shows on intReq in the cycle after the edge that samples it. The bench therefore drives on a falling edge and checks intReq at the next falling edge. The vector is registered on the edge that takes the second acknowledge pulse, so vecValid and vecOut are valid for the falling edge that follows. The acknowledge task queues the expected vector before it starts the handshake, and a monitor pops the queue at every falling edge where vecValid is high. In-service state is not a port, so end-of-interrupt, rotation and spurious handling are checked through which request the next handshake returns and whether intReq is allowed to rise.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int NUM_IRQ = 8;
  localparam int ID_W    = $clog2(NUM_IRQ);
  localparam int DATA_W  = 8;
  localparam int BASE_W  = DATA_W - ID_W;
  localparam int RANK_W  = ID_W + 1;

  // strobes and mode levels from control to datapath
  typedef struct packed {
    logic initWord;
    logic loadBase;
    logic loadMask;
    logic eoi;
    logic eoiSpecific;
    logic eoiRotate;
    logic ackFirst;
    logic ackSecond;
    logic levelMode;
    logic autoEoi;
    logic autoRotate;
  } dpCtrl_t;

  // rank of the best set bit; input lowest+1 has rank 0, NUM_IRQ means none
  function automatic logic [RANK_W-1:0] bestRank(input logic [NUM_IRQ-1:0] vec,
                                                 input logic [ID_W-1:0] lowest);
    logic [RANK_W-1:0] r;
    r = RANK_W'(NUM_IRQ);
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (vec[lowest + ID_W'(1) + ID_W'(k)]) r = RANK_W'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic8_ctrl.sv
module pic8_ctrl import pic8_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrAddr,
  input  logic [7:1]   cmdBits,
  input  logic         ackPulse,
  output dpCtrl_t      ctl
);
  logic waitBase, levelMode, autoEoi, autoRotate, ackPhase;
  logic initWr, opWr;

  assign initWr = wrEn && !wrAddr && cmdBits[4];
  assign opWr   = wrEn && !wrAddr && !cmdBits[4] && !cmdBits[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitBase   <= 1'b0;
      levelMode  <= 1'b0;
      autoEoi    <= 1'b0;
      autoRotate <= 1'b0;
      ackPhase   <= 1'b0;
    end else if (initWr) begin
      waitBase   <= 1'b1;
      levelMode  <= cmdBits[3];
      autoRotate <= cmdBits[2];
      autoEoi    <= cmdBits[1];
      ackPhase   <= 1'b0;
    end else begin
      if (wrEn && wrAddr) waitBase <= 1'b0;
      if (ackPulse) ackPhase <= !ackPhase;
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.initWord    = initWr;
    ctl.loadBase    = wrEn && wrAddr && waitBase;
    ctl.loadMask    = wrEn && wrAddr && !waitBase;
    ctl.eoi         = opWr && cmdBits[5];
    ctl.eoiSpecific = cmdBits[6];
    ctl.eoiRotate   = cmdBits[7];
    ctl.ackFirst    = ackPulse && !ackPhase && !initWr;
    ctl.ackSecond   = ackPulse && ackPhase && !initWr;
    ctl.levelMode   = levelMode;
    ctl.autoEoi     = autoEoi;
    ctl.autoRotate  = autoRotate;
  end
endmodule

// File: rtl/pic8_datapath.sv
module pic8_datapath import pic8_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_IRQ-1:0]  irq,
  output logic                intReq,
  output logic [DATA_W-1:0]   vecOut,
  output logic                vecValid
);
  logic [NUM_IRQ-1:0] irr, isr, imr, irqPrev;
  logic [NUM_IRQ-1:0] sampled, ackSet, isrClr;
  logic [ID_W-1:0]    lowest, ackId, reqId, srvId, eoiId;
  logic [BASE_W-1:0]  base;
  logic [RANK_W-1:0]  reqRank, srvRank;
  logic               ackSpur, reqOk, eoiHit, aeoiDone;

  always_comb begin
    reqRank  = bestRank(irr & ~imr, lowest);
    srvRank  = bestRank(isr, lowest);
    reqOk    = reqRank < srvRank;
    reqId    = lowest + ID_W'(1) + reqRank[ID_W-1:0];
    srvId    = lowest + ID_W'(1) + srvRank[ID_W-1:0];
    eoiId    = ctl.eoiSpecific ? wrData[ID_W-1:0] : srvId;
    eoiHit   = ctl.eoi && (ctl.eoiSpecific || (srvRank != RANK_W'(NUM_IRQ)));
    aeoiDone = ctl.ackSecond && ctl.autoEoi && !ackSpur;
    sampled  = ctl.levelMode ? irq : ((irr | (irq & ~irqPrev)) & irq);
    ackSet   = (ctl.ackFirst && reqOk) ? (NUM_IRQ'(1) << reqId) : '0;
    isrClr   = '0;
    if (eoiHit)   isrClr = isrClr | (NUM_IRQ'(1) << eoiId);
    if (aeoiDone) isrClr = isrClr | (NUM_IRQ'(1) << ackId);
  end

  assign intReq = reqOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr      <= '0;
      isr      <= '0;
      imr      <= '0;
      irqPrev  <= '0;
      lowest   <= '1;
      base     <= '0;
      ackId    <= '1;
      ackSpur  <= 1'b1;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irqPrev  <= irq;
      vecValid <= ctl.ackSecond;
      if (ctl.initWord) begin
        irr    <= '0;
        isr    <= '0;
        imr    <= '0;
        lowest <= '1;
      end else begin
        irr <= sampled & ~ackSet;
        isr <= (isr | ackSet) & ~isrClr;
        if (ctl.loadMask) imr <= wrData[NUM_IRQ-1:0];
        if (eoiHit && ctl.eoiRotate) lowest <= eoiId;
        else if (aeoiDone && ctl.autoRotate) lowest <= ackId;
      end
      if (ctl.loadBase) base <= wrData[DATA_W-1:ID_W];
      if (ctl.ackFirst) begin
        ackId   <= reqOk ? reqId : '1;
        ackSpur <= !reqOk;
      end
      if (ctl.ackSecond) vecOut <= {base, ackId};
    end
  end
endmodule

// File: rtl/pic8_intc.sv
module pic8_intc import pic8_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               ackPulse,
  output logic               intReq,
  output logic [DATA_W-1:0]  vecOut,
  output logic               vecValid
);
  dpCtrl_t ctl;

  pic8_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cmdBits(wrData[7:1]), .ackPulse(ackPulse), .ctl(ctl)
  );

  pic8_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .irq(irq),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: rtl/pic8_intc_chk.sv
module pic8_intc_chk import pic8_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               ackPulse,
  input logic               wrEn,
  input logic               wrAddr,
  input logic               initBit,
  input logic               intReq,
  input logic               vecValid,
  input logic [NUM_IRQ-1:0] irr,
  input logic [NUM_IRQ-1:0] imr,
  input logic [NUM_IRQ-1:0] isr
);
  a_r7_vec_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  a_r7_vec_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackPulse));

  a_r5_unmasked_source: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (|(irr & ~imr)));

  a_r2_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && !wrAddr && initBit) |-> (imr == '0 && isr == '0));

  a_r8_isr_grows_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(isr & ~$past(isr)) != 0) |-> $past(ackPulse));

  a_r7_one_bit_per_ack: assert property (@(posedge clk) disable iff (!rstN)
    $countones(isr & ~$past(isr)) <= 1);
endmodule

bind pic8_intc pic8_intc_chk u_chk (
  .clk(clk), .rstN(rstN), .ackPulse(ackPulse), .wrEn(wrEn), .wrAddr(wrAddr),
  .initBit(wrData[4]), .intReq(intReq), .vecValid(vecValid),
  .irr(u_dp.irr), .imr(u_dp.imr), .isr(u_dp.isr)
);

// File: tb/pic8_intc_tb.sv
module pic8_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irq = '0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       ackPulse = 1'b0;
  logic       intReq, vecValid;
  logic [7:0] vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic8_intc u_dut (
    .clk(clk), .rstN(rstN), .irq(irq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ackPulse(ackPulse), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  // driver: queue the expected vector, then perform the two-pulse handshake
  task automatic ackSeq(input string req, input logic [7:0] exp);
    expQ.push_back(exp);
    tagQ.push_back(req);
    @(negedge clk); ackPulse = 1'b1;
    @(negedge clk); ackPulse = 1'b0;
    @(negedge clk); ackPulse = 1'b1;
    @(negedge clk); ackPulse = 1'b0;
  endtask

  // monitor: compare each delivered vector against the queue
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        chk("R7 unexpected vector", vecOut, 8'hxx);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, vecOut, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 intReq after reset", {7'd0, intReq}, 8'd0);
    chk("R1 vecValid after reset", {7'd0, vecValid}, 8'd0);
    setIrq(8'h01);
    chk("R1 unmasked by default", {7'd0, intReq}, 8'd1);
    ackSeq("R1 base zero vector", 8'h00);
    wr(0, 8'h20);
    setIrq(8'h00);

    wr(0, 8'h10);
    wr(1, 8'h40);
    setIrq(8'h08);
    chk("R3 edge latched", {7'd0, intReq}, 8'd1);
    ackSeq("R7 vector IR3", 8'h43);
    chk("R3 held level no relatch", {7'd0, intReq}, 8'd0);
    setIrq(8'h28);
    chk("R6 lower blocked by in-service", {7'd0, intReq}, 8'd0);
    setIrq(8'h2A);
    chk("R6 higher delivered", {7'd0, intReq}, 8'd1);
    ackSeq("R6 nested vector IR1", 8'h41);
    wr(0, 8'h20);
    chk("R9 nonspecific clears only IR1", {7'd0, intReq}, 8'd0);
    wr(0, 8'h63);
    chk("R10 specific clears IR3", {7'd0, intReq}, 8'd1);
    ackSeq("R10 vector IR5", 8'h45);
    wr(0, 8'h20);
    setIrq(8'h00);

    wr(1, 8'h04);
    setIrq(8'h04);
    chk("R5 masked no request", {7'd0, intReq}, 8'd0);
    wr(1, 8'h00);
    chk("R5 unmask delivers", {7'd0, intReq}, 8'd1);
    setIrq(8'h00);
    chk("R3 fall drops pending", {7'd0, intReq}, 8'd0);
    ackSeq("R8 spurious vector", 8'h47);
    setIrq(8'h80);
    chk("R8 no IR7 in-service left", {7'd0, intReq}, 8'd1);
    ackSeq("R8 real IR7 vector", 8'h47);
    wr(0, 8'h20);
    setIrq(8'h00);

    setIrq(8'h44);
    ackSeq("R6 IR2 before IR6", 8'h42);
    wr(0, 8'hA0);
    setIrq(8'h46);
    ackSeq("R11 rotated IR6 beats IR1", 8'h46);
    wr(0, 8'hE6);
    chk("R11 specific rotate clears", {7'd0, intReq}, 8'd1);
    ackSeq("R11 vector IR1", 8'h41);
    wr(0, 8'h20);
    setIrq(8'h00);

    wr(1, 8'hFF);
    setIrq(8'h90);
    wr(0, 8'h1A);
    wr(1, 8'h80);
    chk("R2 mask cleared R4 level latch", {7'd0, intReq}, 8'd1);
    ackSeq("R2 priority restored IR4", 8'h84);
    chk("R12 auto end clears", {7'd0, intReq}, 8'd1);
    ackSeq("R4 level retrigger IR4", 8'h84);
    setIrq(8'h80);
    ackSeq("R4 level follows IR7", 8'h87);
    setIrq(8'h00);
    chk("R4 level drop clears", {7'd0, intReq}, 8'd0);

    wr(0, 8'h1E);
    wr(1, 8'h80);
    setIrq(8'h09);
    ackSeq("R12 vector IR0", 8'h80);
    ackSeq("R12 rotate after IR0", 8'h83);
    ackSeq("R12 rotate after IR3", 8'h80);
    setIrq(8'h00);

    repeat (2) @(negedge clk);
    chk("R7 all vectors seen", 8'(expQ.size()), 8'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule